// File: doc/BRIEF.md
# Battery Protection Mode Controller

This block is the digital mode sequencer for a multi-cell battery protection front end. It takes comparator flags from the analog section: two supply-level flags with hysteresis, a PACK-supply-present flag, and flags for overload, discharge short circuit and charge short circuit. It also takes a 32 kHz reference clock and one-cycle command strobes from the host serial logic. From these it selects one of six modes. Each mode sets the FET gate-drive enables, the regulator and LED-supply enables, the host reset line, and the enables for the serial interface, current protection, cell measurement, watchdog and thermistor bias.

Fault flags must stay asserted for a set number of 32 kHz ticks before the FETs are dropped. The same reference clock is watched with the free-running system clock. If the reference stops for too long, the controller enters a watchdog-timeout mode that holds the FETs off and pulses the host reset. It leaves that mode as soon as the reference runs again.

Top module: `batt_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 0 (lockout), `rst_out` is 1 and every enable output is 0. Modes are encoded as lockout=0, normal=1, protection=2, watchdog-timeout=3, sleep=4, ship=5.
- R2: From any mode, `sup_below_lo` high moves the block to lockout at the next clock. In lockout, `sup_above_hi` high moves it to normal. While both supply flags are low, the current mode does not change because of supply.
- R3: In normal mode `chg_en`, `dsg_en`, `reg_en`, `led_en`, `ser_en`, `prot_en`, `meas_en`, `wd_en` and `therm_en` are 1. `pchg_en` is 0 in every mode. `chg_en` and `dsg_en` are never 1 outside normal mode.
- R4: After the block leaves lockout, `rst_out` stays 1 for `RST_DLY` system clocks and then goes to 0.
- R5: A fault flag that stays high across its configured number of 32 kHz rising edges (`OVL_DLY`, `SCD_DLY`, `SCC_DLY`) moves the block from normal to protection mode. If the flag drops, its tick count restarts from zero.
- R6: In protection mode the FET enables are 0 and the regulators and all function enables stay 1. `cmd_clear` returns the block to normal only when all three fault flags are low; otherwise the strobe is ignored.
- R7: In normal or protection mode, `WD_LIMIT` system clocks with no detected rising edge on `ref32k` move the block to watchdog-timeout mode, with the FET enables at 0.
- R8: Each watchdog expiry in normal, protection or watchdog-timeout mode drives `rst_out` to 1 for `RST_PULSE` clocks. While the reference stays absent, expiries repeat every `WD_LIMIT` clocks.
- R9: In watchdog-timeout mode, the first detected rising edge of `ref32k` returns the block to normal.
- R10: `cmd_sleep` in normal mode enters sleep. In sleep the FET enables and `therm_en` are 0, while `ser_en`, `prot_en`, `meas_en` and `wd_en` stay 1. `cmd_resume` returns the block to normal.
- R11: `cmd_ship` in normal mode enters ship mode only when `pack_present` is low; with `pack_present` high the strobe is ignored. In ship mode every enable output is 0, and all command strobes are ignored until a supply drop.
- R12: Priority in normal mode is supply drop first, then fault expiry, then watchdog expiry, then ship, then sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_hi | input | 1 | Internal supply above the upper (rise) level |
| sup_below_lo | input | 1 | Internal supply below the lower (fall) level |
| pack_present | input | 1 | Supply detected at the PACK terminal |
| ovl_flag | input | 1 | Sense voltage above the overload threshold |
| scd_flag | input | 1 | Sense voltage above the discharge short-circuit threshold |
| scc_flag | input | 1 | Sense voltage above the charge short-circuit threshold |
| ref32k | input | 1 | 32 kHz reference clock, asynchronous |
| cmd_sleep | input | 1 | Host strobe: enter sleep |
| cmd_ship | input | 1 | Host strobe: enter ship mode |
| cmd_clear | input | 1 | Host strobe: clear protection mode |
| cmd_resume | input | 1 | Host strobe: leave sleep |
| chg_en | output | 1 | Charge FET drive enable |
| dsg_en | output | 1 | Discharge FET drive enable |
| pchg_en | output | 1 | Precharge FET drive enable |
| reg_en | output | 1 | Core regulator enable |
| led_en | output | 1 | LED supply regulator enable |
| rst_out | output | 1 | Host reset, 1 = hold host in reset |
| ser_en | output | 1 | Serial interface enable |
| prot_en | output | 1 | Current protection enable |
| meas_en | output | 1 | Cell measurement enable |
| therm_en | output | 1 | Thermistor bias enable |
| wd_en | output | 1 | Watchdog enable |
| mode_o | output | 3 | Current mode, encoded as in R1 |

## Verification
The bench builds the block with small values: `WD_LIMIT`=40, `RST_DLY`=5, `RST_PULSE`=3, fault delays of 3, 2 and 4 ticks, and a reference period of 16 system clocks. With these values a reference stall, the repeating reset pulse and every blanking count can be observed within a few hundred cycles. Because each fault has its own delay, a count shared between faults or a count that is not restarted would change the cycle in which the mode switches. The bench aligns fault assertion to reference edges so that the tick count at each sample point is known exactly.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

   typedef enum logic [2:0] {
      M_LOCK  = 3'd0,
      M_NORM  = 3'd1,
      M_PROT  = 3'd2,
      M_WDTO  = 3'd3,
      M_SLEEP = 3'd4,
      M_SHIP  = 3'd5
   } mode_e;

   typedef struct packed {
      logic chg;
      logic dsg;
      logic pchg;
      logic reg_on;
      logic led_on;
      logic ser;
      logic prot;
      logic meas;
      logic wd;
      logic therm;
   } drive_t;

   // Output decode per mode; precharge is never driven by this sequencer.
   function automatic drive_t mode_drive(mode_e m);
      drive_t d;
      d = '0;
      case (m)
         M_NORM: begin
            d.chg = 1'b1;  d.dsg = 1'b1;
            d.reg_on = 1'b1; d.led_on = 1'b1;
            d.ser = 1'b1; d.prot = 1'b1; d.meas = 1'b1; d.wd = 1'b1; d.therm = 1'b1;
         end
         M_PROT, M_WDTO: begin
            d.reg_on = 1'b1; d.led_on = 1'b1;
            d.ser = 1'b1; d.prot = 1'b1; d.meas = 1'b1; d.wd = 1'b1; d.therm = 1'b1;
         end
         M_SLEEP: begin
            d.reg_on = 1'b1; d.led_on = 1'b1;
            d.ser = 1'b1; d.prot = 1'b1; d.meas = 1'b1; d.wd = 1'b1;
         end
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/bmc_ref_watch.sv
module bmc_ref_watch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WD_LIMIT    = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic enable,
   output logic tick,
   output logic expire
);
   localparam int unsigned CW = $clog2(WD_LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(WD_LIMIT - 1);

   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q;
   logic [CW-1:0]          cnt_q;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= ref_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], ref_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sh_q[SYNC_STAGES-1];
   end

   assign tick   = sh_q[SYNC_STAGES-1] & ~prev_q;
   assign expire = enable & ~tick & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!enable || tick || expire) cnt_q <= '0;
      else                               cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/bmc_blank.sv
module bmc_blank #(
   parameter int unsigned DLY = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flag,
   input  logic tick,
   output logic hit
);
   localparam int unsigned CW = $clog2(DLY + 1);
   localparam logic [CW-1:0] TOP = CW'(DLY);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clr || !flag)         cnt_q <= '0;
      else if (tick && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign hit = flag & (cnt_q == TOP);

endmodule

// File: rtl/bmc_rst_gen.sv
module bmc_rst_gen #(
   parameter int unsigned RST_DLY   = 1000,
   parameter int unsigned RST_PULSE = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic fire,
   output logic rst_out
);
   localparam int unsigned DW = $clog2(RST_DLY + 1);
   localparam int unsigned PW = $clog2(RST_PULSE + 1);

   logic [DW-1:0] dly_q;
   logic [PW-1:0] pls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           dly_q <= DW'(RST_DLY);
      else if (hold)        dly_q <= DW'(RST_DLY);
      else if (dly_q != '0) dly_q <= dly_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pls_q <= '0;
      else if (hold)        pls_q <= '0;
      else if (fire)        pls_q <= PW'(RST_PULSE);
      else if (pls_q != '0) pls_q <= pls_q - 1'b1;
   end

   assign rst_out = hold | (dly_q != '0) | (pls_q != '0);

endmodule

// File: rtl/batt_mode_ctrl.sv
module batt_mode_ctrl
   import bmc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WD_LIMIT    = 2048,
   parameter int unsigned RST_DLY     = 1000,
   parameter int unsigned RST_PULSE   = 64,
   parameter int unsigned OVL_DLY     = 8,
   parameter int unsigned SCD_DLY     = 2,
   parameter int unsigned SCC_DLY     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sup_above_hi,
   input  logic       sup_below_lo,
   input  logic       pack_present,
   input  logic       ovl_flag,
   input  logic       scd_flag,
   input  logic       scc_flag,
   input  logic       ref32k,
   input  logic       cmd_sleep,
   input  logic       cmd_ship,
   input  logic       cmd_clear,
   input  logic       cmd_resume,
   output logic       chg_en,
   output logic       dsg_en,
   output logic       pchg_en,
   output logic       reg_en,
   output logic       led_en,
   output logic       rst_out,
   output logic       ser_en,
   output logic       prot_en,
   output logic       meas_en,
   output logic       therm_en,
   output logic       wd_en,
   output logic [2:0] mode_o
);
   localparam int unsigned NFLT = 3;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (WD_LIMIT < 4) begin : g_bad_wd
         $error("WD_LIMIT must be at least 4");
      end
      if (OVL_DLY < 1 || SCD_DLY < 1 || SCC_DLY < 1) begin : g_bad_dly
         $error("fault delays must be at least one tick");
      end
      if (RST_PULSE < 1) begin : g_bad_pulse
         $error("RST_PULSE must be at least 1");
      end
   endgenerate

   mode_e  mode_q, mode_d;
   drive_t drv;

   logic            tick, wd_exp, fire;
   logic [NFLT-1:0] flags, hits;
   logic            any_hit, any_flag, blank_clr;

   assign drv = mode_drive(mode_q);

   bmc_ref_watch #(
      .SYNC_STAGES (SYNC_STAGES),
      .WD_LIMIT    (WD_LIMIT)
   ) watch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (ref32k),
      .enable (drv.wd),
      .tick   (tick),
      .expire (wd_exp)
   );

   assign flags     = {scc_flag, scd_flag, ovl_flag};
   assign blank_clr = ~drv.prot;

   generate
      for (genvar g = 0; g < NFLT; g++) begin : g_blank
         localparam int unsigned D = (g == 0) ? OVL_DLY : (g == 1) ? SCD_DLY : SCC_DLY;
         bmc_blank #(.DLY(D)) blank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (blank_clr),
            .flag  (flags[g]),
            .tick  (tick),
            .hit   (hits[g])
         );
      end
   endgenerate

   assign any_hit  = |hits;
   assign any_flag = |flags;

   assign fire = wd_exp & ~sup_below_lo &
                 ((mode_q == M_NORM) | (mode_q == M_PROT) | (mode_q == M_WDTO));

   bmc_rst_gen #(
      .RST_DLY   (RST_DLY),
      .RST_PULSE (RST_PULSE)
   ) rgen_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (mode_q == M_LOCK),
      .fire    (fire),
      .rst_out (rst_out)
   );

   always_comb begin
      mode_d = mode_q;
      if (sup_below_lo) begin
         mode_d = M_LOCK;
      end else begin
         case (mode_q)
            M_LOCK:  if (sup_above_hi) mode_d = M_NORM;
            M_NORM: begin
               if (any_hit)                         mode_d = M_PROT;
               else if (wd_exp)                     mode_d = M_WDTO;
               else if (cmd_ship && !pack_present)  mode_d = M_SHIP;
               else if (cmd_sleep)                  mode_d = M_SLEEP;
            end
            M_PROT: begin
               if (wd_exp)                          mode_d = M_WDTO;
               else if (cmd_clear && !any_flag)     mode_d = M_NORM;
            end
            M_WDTO:  if (tick)       mode_d = M_NORM;
            M_SLEEP: if (cmd_resume) mode_d = M_NORM;
            M_SHIP:  mode_d = M_SHIP;
            default: mode_d = M_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= M_LOCK;
      else        mode_q <= mode_d;
   end

   assign chg_en   = drv.chg;
   assign dsg_en   = drv.dsg;
   assign pchg_en  = drv.pchg;
   assign reg_en   = drv.reg_on;
   assign led_en   = drv.led_on;
   assign ser_en   = drv.ser;
   assign prot_en  = drv.prot;
   assign meas_en  = drv.meas;
   assign therm_en = drv.therm;
   assign wd_en    = drv.wd;
   assign mode_o   = mode_q;

endmodule

// File: rtl/bmc_chk.sv
module bmc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_q,
   input logic       sup_below_lo,
   input logic       any_flag,
   input logic       chg_en,
   input logic       dsg_en,
   input logic       reg_en,
   input logic       ser_en,
   input logic       rst_out
);
   // R2
   supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sup_below_lo |=> (mode_q == 3'd0));

   // R1
   lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd0) |-> (rst_out && !chg_en && !dsg_en && !ser_en && !reg_en));

   // R3
   fet_normal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en || dsg_en) |-> (mode_q == 3'd1));

   // R6
   prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 3'd2) && any_flag) |=> (mode_q != 3'd1));

   // R11
   ship_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 3'd5) && !sup_below_lo) |=> (mode_q == 3'd5));

   // R8
   wdto_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 3'd3) && ($past(mode_q) != 3'd3)) |-> rst_out);

endmodule

bind batt_mode_ctrl bmc_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_q       (mode_o),
   .sup_below_lo (sup_below_lo),
   .any_flag     (ovl_flag | scd_flag | scc_flag),
   .chg_en       (chg_en),
   .dsg_en       (dsg_en),
   .reg_en       (reg_en),
   .ser_en       (ser_en),
   .rst_out      (rst_out)
);

// File: tb/batt_mode_ctrl_tb_top.sv
module batt_mode_ctrl_tb_top;
   localparam int CLK_P     = 10;
   localparam int REF_HALF  = 8 * CLK_P;
   localparam int WD_LIMIT  = 40;
   localparam int RST_DLY   = 5;
   localparam int RST_PULSE = 3;
   localparam int OVL_DLY   = 3;
   localparam int SCD_DLY   = 2;
   localparam int SCC_DLY   = 4;

   logic clk = 0, rst_n = 0;
   logic sup_above_hi = 0, sup_below_lo = 0, pack_present = 1;
   logic ovl_flag = 0, scd_flag = 0, scc_flag = 0;
   logic ref32k = 0, ref_run = 1;
   logic cmd_sleep = 0, cmd_ship = 0, cmd_clear = 0, cmd_resume = 0;
   logic chg_en, dsg_en, pchg_en, reg_en, led_en, rst_out;
   logic ser_en, prot_en, meas_en, therm_en, wd_en;
   logic [2:0] mode_o;

   int n_chk = 0, n_bad = 0;

   batt_mode_ctrl #(
      .SYNC_STAGES (2), .WD_LIMIT (WD_LIMIT), .RST_DLY (RST_DLY),
      .RST_PULSE (RST_PULSE), .OVL_DLY (OVL_DLY), .SCD_DLY (SCD_DLY), .SCC_DLY (SCC_DLY)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .sup_above_hi (sup_above_hi), .sup_below_lo (sup_below_lo),
      .pack_present (pack_present), .ovl_flag (ovl_flag), .scd_flag (scd_flag),
      .scc_flag (scc_flag), .ref32k (ref32k), .cmd_sleep (cmd_sleep), .cmd_ship (cmd_ship),
      .cmd_clear (cmd_clear), .cmd_resume (cmd_resume), .chg_en (chg_en), .dsg_en (dsg_en),
      .pchg_en (pchg_en), .reg_en (reg_en), .led_en (led_en), .rst_out (rst_out),
      .ser_en (ser_en), .prot_en (prot_en), .meas_en (meas_en), .therm_en (therm_en),
      .wd_en (wd_en), .mode_o (mode_o)
   );

   initial forever #(CLK_P/2) clk = ~clk;

   initial forever begin
      #(REF_HALF);
      if (ref_run) ref32k = ~ref32k;
      else         ref32k = 1'b0;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // packed enables: chg dsg pchg reg led ser prot meas wd therm
   function automatic int en_vec();
      return {chg_en, dsg_en, pchg_en, reg_en, led_en, ser_en, prot_en, meas_en, wd_en, therm_en};
   endfunction

   task automatic clocks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic after_ref_edges(input int n);
      for (int i = 0; i < n; i++) @(posedge ref32k);
      clocks(5);
   endtask

   task automatic strobe(input int which);
      @(negedge clk);
      case (which)
         0: cmd_sleep = 1;
         1: cmd_ship = 1;
         2: cmd_clear = 1;
         default: cmd_resume = 1;
      endcase
      @(negedge clk);
      cmd_sleep = 0; cmd_ship = 0; cmd_clear = 0; cmd_resume = 0;
   endtask

   task automatic t_reset();
      clocks(3);
      chk("R1", "mode in reset", mode_o, 0);
      chk("R1", "rst_out in reset", rst_out, 1);
      chk("R1", "enables in reset", en_vec(), 0);
      rst_n = 1;
      clocks(4);
      chk("R2", "lockout held, both supply flags low", mode_o, 0);
   endtask

   task automatic t_powerup();
      @(negedge clk) sup_above_hi = 1;
      @(negedge clk) sup_above_hi = 0;
      chk("R2", "lockout exit", mode_o, 1);
      chk("R4", "reset held on entry", rst_out, 1);
      clocks(RST_DLY - 1);
      chk("R4", "reset still held at last delay cycle", rst_out, 1);
      clocks(1);
      chk("R4", "reset released", rst_out, 0);
      chk("R3", "normal enables", en_vec(), 10'b1101111111);
      chk("R3", "precharge off", pchg_en, 0);
      clocks(20);
      chk("R2", "normal held, supply between levels", mode_o, 1);
   endtask

   task automatic set_flag(input int which, input logic v);
      case (which)
         0: ovl_flag = v;
         1: scd_flag = v;
         default: scc_flag = v;
      endcase
   endtask

   task automatic t_fault(input int which, input int dly, input string nm);
      after_ref_edges(1);
      set_flag(which, 1);
      after_ref_edges(dly - 1);
      chk("R5", {nm, " one tick short"}, mode_o, 1);
      after_ref_edges(1);
      chk("R5", {nm, " blanking expired"}, mode_o, 2);
      chk("R6", {nm, " protection enables"}, en_vec(), 10'b0001111111);
      strobe(2);
      chk("R6", {nm, " clear ignored with flag high"}, mode_o, 2);
      set_flag(which, 0);
      strobe(2);
      chk("R6", {nm, " clear accepted"}, mode_o, 1);
   endtask

   task automatic t_fault_restart();
      after_ref_edges(1);
      scd_flag = 1;
      after_ref_edges(SCD_DLY - 1);
      scd_flag = 0;
      after_ref_edges(1);
      scd_flag = 1;
      after_ref_edges(SCD_DLY - 1);
      chk("R5", "count restarts after drop", mode_o, 1);
      after_ref_edges(1);
      chk("R5", "restarted count expires", mode_o, 2);
      scd_flag = 0;
      strobe(2);
   endtask

   task automatic t_sleep();
      strobe(0);
      chk("R10", "sleep entry", mode_o, 4);
      chk("R10", "sleep enables", en_vec(), 10'b0001111110);
      strobe(3);
      chk("R10", "resume", mode_o, 1);
   endtask

   task automatic t_ship();
      pack_present = 1;
      strobe(1);
      chk("R11", "ship ignored with pack supply", mode_o, 1);
      pack_present = 0;
      @(negedge clk) begin cmd_ship = 1; cmd_sleep = 1; end
      @(negedge clk) begin cmd_ship = 0; cmd_sleep = 0; end
      chk("R12", "ship wins over sleep", mode_o, 5);
      chk("R11", "ship enables", en_vec(), 0);
      strobe(3);
      strobe(2);
      strobe(0);
      chk("R11", "commands ignored in ship", mode_o, 5);
      @(negedge clk) sup_below_lo = 1;
      @(negedge clk) sup_below_lo = 0;
      chk("R2", "supply drop leaves ship", mode_o, 0);
      pack_present = 1;
      @(negedge clk) sup_above_hi = 1;
      @(negedge clk) sup_above_hi = 0;
      chk("R2", "power up again", mode_o, 1);
      clocks(RST_DLY + 2);
   endtask

   task automatic t_drop_priority();
      @(negedge clk) begin sup_below_lo = 1; cmd_sleep = 1; end
      @(negedge clk) begin sup_below_lo = 0; cmd_sleep = 0; end
      chk("R12", "supply drop wins over sleep", mode_o, 0);
      chk("R1", "lockout reset high", rst_out, 1);
      @(negedge clk) sup_above_hi = 1;
      @(negedge clk) sup_above_hi = 0;
      clocks(RST_DLY + 2);
   endtask

   task automatic t_watchdog();
      bit got = 0;
      @(negedge clk) ref_run = 0;
      clocks(15);
      chk("R7", "no early timeout", mode_o, 1);
      for (int i = 0; i < 200 && !got; i++) begin
         @(negedge clk);
         if (mode_o == 3) got = 1;
      end
      chk("R7", "timeout reached", got, 1);
      chk("R7", "FETs off in timeout", {chg_en, dsg_en}, 0);
      chk("R8", "pulse on entry", rst_out, 1);
      clocks(RST_PULSE);
      chk("R8", "pulse ended", rst_out, 0);
      clocks(WD_LIMIT - 1 - RST_PULSE);
      chk("R8", "no pulse before next expiry", rst_out, 0);
      clocks(1);
      chk("R8", "pulse repeats", rst_out, 1);
      chk("R8", "still in timeout", mode_o, 3);
      ref_run = 1;
      got = 0;
      for (int i = 0; i < 60 && !got; i++) begin
         @(negedge clk);
         if (mode_o == 1) got = 1;
      end
      chk("R9", "back to normal on reference", got, 1);
      clocks(RST_PULSE + 1);
      chk("R9", "FETs on after recovery", {chg_en, dsg_en}, 3);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      t_reset();
      t_powerup();
      t_fault(0, OVL_DLY, "overload");
      t_fault(1, SCD_DLY, "discharge short");
      t_fault(2, SCC_DLY, "charge short");
      t_fault_restart();
      t_sleep();
      t_ship();
      t_drop_priority();
      t_watchdog();
      summary();
   end

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule